// File: doc/BRIEF.md
# Vector Bitwise Logic and Scalar Fill Unit

This unit is the execute stage for whole-register bitwise work on 128-bit vector registers. It takes the current destination vector along with the source and target vectors. It computes one of four plain bitwise operations (AND, OR, NOR, XOR) or one of three bit-merge operations. The merge operations use the old destination value as a third operand. The unit also performs a fill: a 64-bit scalar is cut down to the lane width and the result is copied into every lane. The lanes can be 16 bytes, 8 halfwords, 4 words or 2 doublewords.

The surrounding pipeline reads the register file, presents one operation per cycle with `op_vld` high, and writes `res_vec` back when `wr_en` is high. Operations that cannot execute raise `rsvd_flag`, and nothing is written for them. This covers any opcode select outside the defined set, and a doubleword fill while 64-bit mode is off.

Control is a two-state machine. `ST_IDLE` is the state after reset and whenever no operation was captured. `ST_EMIT` is entered on the transition "capture", which happens on any clock edge where `op_vld` is high. The machine leaves `ST_EMIT` on the transition "drain" when `op_vld` is low at the next edge. It stays in `ST_EMIT` on the transition "stream" when another operation arrives at that edge. The registered outputs are qualified in `ST_EMIT`.

Top module: `vec_logic_fill`

## Requirements
- R1: After reset `res_vld`, `wr_en` and `rsvd_flag` are 0. An operation presented with `op_vld` high at a rising edge is reported with `res_vld` high during the following cycle. With no operation presented, the next cycle shows `res_vld`, `wr_en` and `rsvd_flag` all at 0.
- R2: Opcode select 0 gives ws AND wt, 1 gives ws OR wt, 2 gives NOT(ws OR wt), and 3 gives ws XOR wt. All of them work over the whole 128 bits, whatever the format code.
- R3: Opcode select 4 (move-if-not-zero) gives, per bit, the source bit where the target bit is 1 and the old destination bit where it is 0.
- R4: Opcode select 5 (move-if-zero) gives, per bit, the source bit where the target bit is 0 and the old destination bit where it is 1.
- R5: Opcode select 6 (bit-select) gives, per bit, the target bit where the old destination bit is 1 and the source bit where it is 0.
- R6: Opcode select 7 (fill) writes every lane with the low bits of the scalar. The lane width comes from the format code: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64.
- R7: A fill with format code 3 while `mode64` is 0 raises `rsvd_flag`, holds `wr_en` at 0, and returns the old destination unchanged on `res_vec`.
- R8: Opcode selects 8 to 15 raise `rsvd_flag`, hold `wr_en` at 0, and return the old destination unchanged on `res_vec`.
- R9: `wr_en` is high exactly when `res_vld` is high and `rsvd_flag` is low. Every accepted operation has `rsvd_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Operation presented this cycle |
| op_sel | input | 4 | Opcode select (0-7 defined, 8-15 reserved) |
| fmt | input | 2 | Lane format for fill: 0 byte, 1 half, 2 word, 3 double |
| mode64 | input | 1 | 64-bit mode enable; permits doubleword fill |
| wd_vec | input | 128 | Current destination vector |
| ws_vec | input | 128 | Source vector |
| wt_vec | input | 128 | Target vector |
| scalar | input | 64 | General-purpose register value for fill |
| res_vld | output | 1 | Registered result qualifier, one cycle after `op_vld` |
| wr_en | output | 1 | Write-back enable for `res_vec` |
| rsvd_flag | output | 1 | Reserved-instruction indication |
| res_vec | output | 128 | New destination vector |

## Verification
The hardest situation to reach is the rejected doubleword fill. Three inputs have to line up on one cycle: opcode select 7, format code 3, and `mode64` low. The old destination must also differ from every legal result, or a silent write would go unnoticed. The bench gets there by sweeping every opcode select against every format code and both `mode64` values. It uses destination patterns that differ from both the scalar and the source, and checks that `res_vec` still equals the old destination while the write enable stays off. The merge operations are hard to tell apart because they differ only in which operand steers each bit. Complementary and mixed patterns across the three vectors make each operand's role visible.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

    localparam int VEC_W    = 128;
    localparam int SCALAR_W = 64;
    localparam int N_FMT    = 4;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_NOR  = 4'd2,
        OP_XOR  = 4'd3,
        OP_MNZ  = 4'd4,
        OP_MZ   = 4'd5,
        OP_SEL  = 4'd6,
        OP_FILL = 4'd7
    } vop_e;

    typedef enum logic [1:0] {
        FMT_B = 2'd0,
        FMT_H = 2'd1,
        FMT_W = 2'd2,
        FMT_D = 2'd3
    } vfmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } vstate_e;

endpackage

// File: rtl/vlf_logic_unit.sv
module vlf_logic_unit
    import vlf_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] wd,
    input  logic [W-1:0] ws,
    input  logic [W-1:0] wt,
    output logic [W-1:0] res
);

    always_comb begin
        case (op)
            OP_AND:  res = ws & wt;
            OP_OR:   res = ws | wt;
            OP_NOR:  res = ~(ws | wt);
            OP_XOR:  res = ws ^ wt;
            OP_MNZ:  res = (ws & wt) | (wd & ~wt);
            OP_MZ:   res = (ws & ~wt) | (wd & wt);
            OP_SEL:  res = (ws & ~wd) | (wt & wd);
            default: res = wd;
        endcase
    end

endmodule

// File: rtl/vlf_fill_unit.sv
module vlf_fill_unit
    import vlf_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int SW = SCALAR_W
) (
    input  logic [1:0]    fmt,
    input  logic [SW-1:0] scalar,
    output logic [W-1:0]  res
);

    logic [N_FMT-1:0][W-1:0] rep;

    for (genvar f = 0; f < N_FMT; f++) begin : g_fmt
        localparam int LW = 8 << f;
        localparam int NL = W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            assign rep[f][l*LW +: LW] = scalar[LW-1:0];
        end
    end

    assign res = rep[fmt];

endmodule

// File: rtl/vec_logic_fill.sv
module vec_logic_fill
    import vlf_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int SW = SCALAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_vld,
    input  logic [3:0]    op_sel,
    input  logic [1:0]    fmt,
    input  logic          mode64,
    input  logic [W-1:0]  wd_vec,
    input  logic [W-1:0]  ws_vec,
    input  logic [W-1:0]  wt_vec,
    input  logic [SW-1:0] scalar,
    output logic          res_vld,
    output logic          wr_en,
    output logic          rsvd_flag,
    output logic [W-1:0]  res_vec
);

    vstate_e       state_q;
    vstate_e       state_d;
    logic [W-1:0]  logic_res;
    logic [W-1:0]  fill_res;
    logic [W-1:0]  next_res;
    logic          next_bad;
    logic [W-1:0]  res_q;
    logic          wr_q;
    logic          bad_q;

    vlf_logic_unit #(.W(W)) u_logic (
        .op  (op_sel),
        .wd  (wd_vec),
        .ws  (ws_vec),
        .wt  (wt_vec),
        .res (logic_res)
    );

    vlf_fill_unit #(.W(W), .SW(SW)) u_fill (
        .fmt    (fmt),
        .scalar (scalar),
        .res    (fill_res)
    );

    // Result selection and reserved-instruction decode
    always_comb begin
        next_res = wd_vec;
        next_bad = 1'b0;
        case (op_sel)
            OP_AND, OP_OR, OP_NOR, OP_XOR,
            OP_MNZ, OP_MZ, OP_SEL: begin
                next_res = logic_res;
            end
            OP_FILL: begin
                if (fmt == FMT_D && !mode64) begin
                    next_bad = 1'b1;
                end else begin
                    next_res = fill_res;
                end
            end
            default: begin
                next_bad = 1'b1;
            end
        endcase
    end

    // Next-state: capture / stream into ST_EMIT, drain back to ST_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_vld)  state_d = ST_EMIT;
            ST_EMIT: if (!op_vld) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            wr_q  <= 1'b0;
            bad_q <= 1'b0;
        end else if (op_vld) begin
            res_q <= next_res;
            wr_q  <= !next_bad;
            bad_q <= next_bad;
        end else begin
            wr_q  <= 1'b0;
            bad_q <= 1'b0;
        end
    end

    assign res_vld   = (state_q == ST_EMIT);
    assign wr_en     = wr_q;
    assign rsvd_flag = bad_q;
    assign res_vec   = res_q;

endmodule

// File: rtl/vlf_checker.sv
module vlf_checker #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_vld,
    input logic [3:0]   op_sel,
    input logic [1:0]   fmt,
    input logic         mode64,
    input logic [W-1:0] wd_vec,
    input logic [W-1:0] ws_vec,
    input logic [W-1:0] wt_vec,
    input logic         res_vld,
    input logic         wr_en,
    input logic         rsvd_flag,
    input logic [W-1:0] res_vec
);

    assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> res_vld);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> (!res_vld && !wr_en && !rsvd_flag));

    assert_nor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel == 4'd2) |=> (res_vec == ~($past(ws_vec) | $past(wt_vec))));

    assert_mnz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel == 4'd4) |=>
            (res_vec == (($past(ws_vec) & $past(wt_vec)) | ($past(wd_vec) & ~$past(wt_vec)))));

    assert_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel == 4'd6) |=>
            (res_vec == (($past(ws_vec) & ~$past(wd_vec)) | ($past(wt_vec) & $past(wd_vec)))));

    assert_dfill_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel == 4'd7 && fmt == 2'd3 && !mode64) |=>
            (rsvd_flag && !wr_en && res_vec == $past(wd_vec)));

    assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_sel[3]) |=> (rsvd_flag && !wr_en && res_vec == $past(wd_vec)));

    assert_wr_gating_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (res_vld && !rsvd_flag));

    assert_flag_needs_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_flag |-> res_vld);

endmodule

bind vec_logic_fill vlf_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_vld    (op_vld),
    .op_sel    (op_sel),
    .fmt       (fmt),
    .mode64    (mode64),
    .wd_vec    (wd_vec),
    .ws_vec    (ws_vec),
    .wt_vec    (wt_vec),
    .res_vld   (res_vld),
    .wr_en     (wr_en),
    .rsvd_flag (rsvd_flag),
    .res_vec   (res_vec)
);

// File: tb/sim_vec_logic_fill.sv
`timescale 1ns/1ps
module sim_vec_logic_fill;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_vld = 1'b0;
    logic [3:0]   op_sel = '0;
    logic [1:0]   fmt = '0;
    logic         mode64 = 1'b0;
    logic [127:0] wd_vec = '0;
    logic [127:0] ws_vec = '0;
    logic [127:0] wt_vec = '0;
    logic [63:0]  scalar = '0;
    logic         res_vld;
    logic         wr_en;
    logic         rsvd_flag;
    logic [127:0] res_vec;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vec_logic_fill u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_vld    (op_vld),
        .op_sel    (op_sel),
        .fmt       (fmt),
        .mode64    (mode64),
        .wd_vec    (wd_vec),
        .ws_vec    (ws_vec),
        .wt_vec    (wt_vec),
        .scalar    (scalar),
        .res_vld   (res_vld),
        .wr_en     (wr_en),
        .rsvd_flag (rsvd_flag),
        .res_vec   (res_vec)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_result(input logic [3:0] op, input logic [1:0] f,
                                                input logic m64, input logic [127:0] d,
                                                input logic [127:0] s, input logic [127:0] t,
                                                input logic [63:0] sc, output logic bad);
        logic [127:0] r;
        int lw;
        bad = 1'b0;
        r = d;
        lw = 8 << f;
        for (int i = 0; i < 128; i++) begin
            case (op)
                4'd0: r[i] = s[i] & t[i];
                4'd1: r[i] = s[i] | t[i];
                4'd2: r[i] = !(s[i] | t[i]);
                4'd3: r[i] = s[i] ^ t[i];
                4'd4: r[i] = t[i] ? s[i] : d[i];
                4'd5: r[i] = t[i] ? d[i] : s[i];
                4'd6: r[i] = d[i] ? t[i] : s[i];
                4'd7: if (!(f == 2'd3 && !m64)) r[i] = sc[i % lw];
                default: r[i] = d[i];
            endcase
        end
        if (op >= 4'd8 || (op == 4'd7 && f == 2'd3 && !m64)) bad = 1'b1;
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic [1:0] f, input logic m64);
        if (op >= 4'd8) return "R8";
        case (op)
            4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return (f == 2'd3 && !m64) ? "R7" : "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [1:0] f, input logic m64,
                          input logic [127:0] d, input logic [127:0] s,
                          input logic [127:0] t, input logic [63:0] sc);
        logic [127:0] exp;
        logic bad;
        string rq;
        exp = ref_result(op, f, m64, d, s, t, sc, bad);
        rq = req_of(op, f, m64);
        @(negedge clk);
        op_vld = 1'b1; op_sel = op; fmt = f; mode64 = m64;
        wd_vec = d; ws_vec = s; wt_vec = t; scalar = sc;
        @(negedge clk);
        op_vld = 1'b0;
        wd_vec = ~d; ws_vec = ~s; wt_vec = ~t; scalar = ~sc;
        chk("R1", {127'd0, res_vld}, 128'd1);
        chk(rq, res_vec, exp);
        chk(rq, {127'd0, rsvd_flag}, {127'd0, bad});
        chk("R9", {127'd0, wr_en}, {127'd0, !bad});
        @(negedge clk);
        chk("R1", {125'd0, res_vld, wr_en, rsvd_flag}, 128'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] d, s, t;
        logic [63:0] sc;
        repeat (3) @(negedge clk);
        chk("R1", {125'd0, res_vld, wr_en, rsvd_flag}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {125'd0, res_vld, wr_en, rsvd_flag}, 128'd0);
        for (int p = 0; p < 6; p++) begin
            case (p)
                0: begin d = '0; s = '1; t = {8{16'hF00F}}; sc = 64'h0123_4567_89AB_CDEF; end
                1: begin d = '1; s = '0; t = {8{16'h0FF0}}; sc = 64'hFEDC_BA98_7654_3210; end
                2: begin d = {4{32'hAAAA_5555}}; s = {4{32'h3C3C_C3C3}}; t = {4{32'h0F0F_F0F0}}; sc = 64'h8000_0001_7FFF_FFFE; end
                default: begin
                    d = {4{32'h1234_5678 ^ (p * 32'h9E37_79B9)}};
                    s = {4{32'hCAFE_F00D + (p * 32'h0101_0101)}} ^ {32'h0, d[95:0]};
                    t = {d[63:0], s[127:64]} ^ {4{32'h5A5A_A5A5 * p}};
                    sc = {d[31:0], s[31:0]} ^ 64'h0F1E_2D3C_4B5A_6978;
                end
            endcase
            for (int op = 0; op < 16; op++)
                for (int f = 0; f < 4; f++)
                    for (int m = 0; m < 2; m++)
                        run_op(op[3:0], f[1:0], m[0], d, s, t, sc);
        end
        // back-to-back stream: second result lands the cycle after the first
        @(negedge clk);
        op_vld = 1'b1; op_sel = 4'd0; wd_vec = '0; ws_vec = '1; wt_vec = {64'h0, 64'hFFFF};
        @(negedge clk);
        chk("R2", res_vec, {64'h0, 64'hFFFF});
        op_sel = 4'd7; fmt = 2'd1; mode64 = 1'b0; scalar = 64'h1111_2222_3333_ABCD;
        @(negedge clk);
        op_vld = 1'b0;
        chk("R1", {127'd0, res_vld}, 128'd1);
        chk("R6", res_vec, {8{16'hABCD}});
        @(negedge clk);
        chk("R1", {127'd0, res_vld}, 128'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule